// File: doc/BRIEF.md
# Vectored Interrupt Character Input Port

This block is a memory-mapped input port for single characters on a 32-bit bus. A device-side source hands it one character at a time. The block holds that character and, if interrupts are enabled, raises a request on a shared, OR-combined interrupt line. A processor reads a control register to see the port's state and set it up, and reads a data register to collect the character. Reading the data register also frees the port for the next character.

Several such ports share one request line and sit on an acknowledge chain. An acknowledge enters at `ack_in`. A port that is requesting keeps the acknowledge and drives its handler address on `ack_vec`. A port that is not requesting passes the acknowledge on through `ack_out`. The port nearest the head of the chain therefore wins.

The character input follows valid/ready rules. A character is taken on a clock edge where `chr_valid` and `chr_ready` are both high. `chr_ready` is low while a character is held. The port gives back-pressure only through `chr_ready`. A source that still presents `chr_valid` while `chr_ready` is low loses that character, and the port records an overrun. Bus accesses take effect on the rising clock edge. Read data is combinational during the cycle in which `bus_rd` is high.

Top module: `cip_char_port`

## Requirements
- R1: After reset the control register reads 0, `irq_out` is low, `chr_ready` is high and `ack_out` follows `ack_in`.
- R2: A write to the control register (`bus_addr`=0) stores the vector from bits 11:4 and the enable from bit 0. Bits 28:12 and 3:1 always read as 0. Writing 0x1F1 reads back as 0x1F1 when no character is held.
- R3: A character is taken when `chr_valid` and `chr_ready` are high at a clock edge. Afterwards the ready flag (control bit 31) is 1 and `chr_ready` is low.
- R4: A read of the data register (`bus_addr`=1) returns the held character zero-extended in bits 7:0. It clears the ready flag, so `chr_ready` is high in the next cycle.
- R5: `irq_out` equals ready AND enable, and control bit 30 reads the same value.
- R6: Writing 0 to the control register lowers `irq_out` by the next cycle.
- R7: A character presented while the ready flag is set is dropped. The held character is kept and the overrun flag (control bit 29) is set.
- R8: A control register read clears the overrun flag. If a new overrun happens in the same cycle, the flag stays set.
- R9: `ack_out` = `ack_in` AND NOT `irq_out`.
- R10: When `ack_in` and `irq_out` are both high, `ack_oe` is high and `ack_vec` = vector << 4. Otherwise `ack_oe` is low and `ack_vec` is 0.
- R11: A write to the data register changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | Register select: 0 control, 1 data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when not reading |
| chr_valid | input | 1 | Source presents a character |
| chr_data | input | 8 | Character from the source |
| chr_ready | output | 1 | Port can take a character |
| irq_out | output | 1 | Interrupt request, OR-combined outside |
| ack_in | input | 1 | Acknowledge from the previous chain stage |
| ack_out | output | 1 | Acknowledge to the next chain stage |
| ack_oe | output | 1 | Port holds the acknowledge and drives its vector |
| ack_vec | output | 32 | Handler address while `ack_oe` is high |

## Verification
A held character that is lost or held too long shows at once on `chr_ready` and on `irq_out`. It also shows in the ready bit that the next control read returns. A wrong overrun state shows only on a control read, so the bench reads the control register twice in a row to see both the set and the clear. The chain outputs are combinational, so a wrong enable or vector shows on `ack_out`, `ack_oe` and `ack_vec` in the same cycle that `ack_in` rises.

// File: rtl/cip_pkg.sv
package cip_pkg;
  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_DATA = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/cip_slot.sv
module cip_slot #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  input  logic              take,
  input  logic              clr_ovr,
  output logic              full,
  output logic              ovr,
  output logic [CHAR_W-1:0] held
);
  logic              full_q, ovr_q;
  logic [CHAR_W-1:0] held_q;
  logic              accept, lost;

  assign accept = in_valid && !full_q;
  assign lost   = in_valid && full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      held_q <= '0;
    end else if (accept) begin
      full_q <= 1'b1;
      held_q <= in_data;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ovr_q <= 1'b0;
    else if (lost)    ovr_q <= 1'b1;
    else if (clr_ovr) ovr_q <= 1'b0;
  end

  assign in_ready = !full_q;
  assign full     = full_q;
  assign ovr      = ovr_q;
  assign held     = held_q;
endmodule

// File: rtl/cip_ctl.sv
module cip_ctl #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [VEC_W-1:0] wr_vec,
  input  logic             wr_enable,
  output logic [VEC_W-1:0] vec,
  output logic             enable
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec    <= '0;
      enable <= 1'b0;
    end else if (wr_en) begin
      vec    <= wr_vec;
      enable <= wr_enable;
    end
  end
endmodule

// File: rtl/cip_chain.sv
module cip_chain #(
  parameter int DATA_W  = 32,
  parameter int VEC_W   = 8,
  parameter int VEC_LSB = 4
) (
  input  logic              pending,
  input  logic              enable,
  input  logic [VEC_W-1:0]  vec,
  input  logic              ack_in,
  output logic              irq,
  output logic              ack_out,
  output logic              ack_oe,
  output logic [DATA_W-1:0] ack_vec
);
  logic win;

  assign irq     = pending && enable;
  assign win     = ack_in && irq;
  assign ack_out = ack_in && !irq;
  assign ack_oe  = win;

  for (genvar i = 0; i < DATA_W; i++) begin : g_vbit
    if (i >= VEC_LSB && i < VEC_LSB + VEC_W) begin : g_on
      assign ack_vec[i] = win && vec[i-VEC_LSB];
    end else begin : g_off
      assign ack_vec[i] = 1'b0;
    end
  end
endmodule

// File: rtl/cip_char_port.sv
module cip_char_port #(
  parameter int DATA_W  = 32,
  parameter int CHAR_W  = 8,
  parameter int VEC_W   = 8,
  parameter int VEC_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              chr_valid,
  input  logic [CHAR_W-1:0] chr_data,
  output logic              chr_ready,
  output logic              irq_out,
  input  logic              ack_in,
  output logic              ack_out,
  output logic              ack_oe,
  output logic [DATA_W-1:0] ack_vec
);
  import cip_pkg::*;

  localparam int RDY_BIT = DATA_W - 1;
  localparam int REQ_BIT = DATA_W - 2;
  localparam int OVR_BIT = DATA_W - 3;
  localparam int EN_BIT  = 0;
  localparam int VEC_MSB = VEC_LSB + VEC_W - 1;

  reg_sel_e          sel;
  logic              ctrl_wr, ctrl_rd, data_rd;
  logic              full_q, ovr_q, enable_q;
  logic [CHAR_W-1:0] held_q;
  logic [VEC_W-1:0]  vec_q;
  logic              wdata_unused;

  assign sel     = reg_sel_e'(bus_addr);
  assign ctrl_wr = bus_wr && (sel == SEL_CTRL);
  assign ctrl_rd = bus_rd && (sel == SEL_CTRL);
  assign data_rd = bus_rd && (sel == SEL_DATA);
  assign wdata_unused = ^{bus_wdata[DATA_W-1:VEC_MSB+1], bus_wdata[VEC_LSB-1:EN_BIT+1]};

  cip_slot #(.CHAR_W(CHAR_W)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (chr_valid),
    .in_data  (chr_data),
    .in_ready (chr_ready),
    .take     (data_rd),
    .clr_ovr  (ctrl_rd),
    .full     (full_q),
    .ovr      (ovr_q),
    .held     (held_q)
  );

  cip_ctl #(.VEC_W(VEC_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ctrl_wr),
    .wr_vec    (bus_wdata[VEC_MSB:VEC_LSB]),
    .wr_enable (bus_wdata[EN_BIT]),
    .vec       (vec_q),
    .enable    (enable_q)
  );

  cip_chain #(.DATA_W(DATA_W), .VEC_W(VEC_W), .VEC_LSB(VEC_LSB)) u_chain (
    .pending (full_q),
    .enable  (enable_q),
    .vec     (vec_q),
    .ack_in  (ack_in),
    .irq     (irq_out),
    .ack_out (ack_out),
    .ack_oe  (ack_oe),
    .ack_vec (ack_vec)
  );

  always_comb begin
    bus_rdata = '0;
    if (ctrl_rd) begin
      bus_rdata[RDY_BIT]         = full_q;
      bus_rdata[REQ_BIT]         = irq_out;
      bus_rdata[OVR_BIT]         = ovr_q;
      bus_rdata[VEC_MSB:VEC_LSB] = vec_q;
      bus_rdata[EN_BIT]          = enable_q;
    end else if (data_rd) begin
      bus_rdata[CHAR_W-1:0] = held_q;
    end
  end
endmodule

// File: rtl/cip_char_port_chk.sv
module cip_char_port_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              chr_valid,
  input logic              chr_ready,
  input logic              irq_out,
  input logic              ack_in,
  input logic              ack_out,
  input logic              ack_oe,
  input logic [DATA_W-1:0] ack_vec,
  input logic              ovr
);
  assert_ack_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out |-> (ack_in && !irq_out));

  assert_ack_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_out && ack_oe));

  assert_vec_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_oe |-> (ack_vec == '0));

  assert_irq_needs_char_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> !chr_ready);

  assert_read_rearm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr && !chr_ready) |=> chr_ready);

  assert_disable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr && !bus_wdata[0]) |=> !irq_out);

  assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_valid && !chr_ready) |=> ovr);
endmodule

bind cip_char_port cip_char_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .chr_valid (chr_valid),
  .chr_ready (chr_ready),
  .irq_out   (irq_out),
  .ack_in    (ack_in),
  .ack_out   (ack_out),
  .ack_oe    (ack_oe),
  .ack_vec   (ack_vec),
  .ovr       (ovr_q)
);

// File: tb/tb_cip_char_port.sv
`timescale 1ns/1ps
module tb_cip_char_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        chr_valid = 1'b0;
  logic [7:0]  chr_data = '0;
  logic        chr_ready, irq_out, ack_out, ack_oe;
  logic        ack_in = 1'b0;
  logic [31:0] ack_vec;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  cip_char_port dut (.*);

  // monitor: compares every read against the scoreboard
  always @(negedge clk) begin
    if (rst_n && bus_rd) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL unexpected read: actual %h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (bus_rdata !== e) begin
          fails++;
          $display("FAIL %s read: actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    bus_wr = 0; bus_rd = 0; chr_valid = 0;
  endtask

  task automatic rd(input logic a, input logic [31:0] exp, input string t);
    bus_addr = a; bus_rd = 1;
    exp_q.push_back(exp); tag_q.push_back(t);
    step();
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    bus_addr = a; bus_wr = 1; bus_wdata = d;
    step();
  endtask

  task automatic send(input logic [7:0] c);
    chr_valid = 1; chr_data = c;
    step();
  endtask

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    ack_in = 1; #1;
    chk("R1 chr_ready", {31'b0, chr_ready}, 1);
    chk("R1 irq_out", {31'b0, irq_out}, 0);
    chk("R1 ack_out", {31'b0, ack_out}, 1);
    ack_in = 0;
    rd(0, 32'h0, "R1 ctrl");
    // R2 control fields
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h0000_0FF1, "R2 reserved");
    wr(0, 32'h0000_01F1);
    rd(0, 32'h0000_01F1, "R2 ctrl");
    // R3 R5 character arrives
    send(8'h41);
    chk("R3 chr_ready", {31'b0, chr_ready}, 0);
    chk("R5 irq_out", {31'b0, irq_out}, 1);
    rd(0, 32'hC000_01F1, "R3 R5 ctrl");
    // R9 R10 acknowledge won
    ack_in = 1; #1;
    chk("R9 ack_out", {31'b0, ack_out}, 0);
    chk("R10 ack_oe", {31'b0, ack_oe}, 1);
    chk("R10 ack_vec", ack_vec, 32'h0000_01F0);
    ack_in = 0; #1;
    chk("R10 ack_oe idle", {31'b0, ack_oe}, 0);
    // R11 data write ignored
    wr(1, 32'h0000_0055);
    rd(0, 32'hC000_01F1, "R11 ctrl");
    // R7 R8 overrun
    send(8'h42);
    rd(0, 32'hE000_01F1, "R7 ctrl");
    rd(0, 32'hC000_01F1, "R8 clear");
    // R4 data read
    rd(1, 32'h0000_0041, "R4 R7 R11 data");
    chk("R4 chr_ready", {31'b0, chr_ready}, 1);
    chk("R4 irq_out", {31'b0, irq_out}, 0);
    // R8 set beats clear
    send(8'h10);
    chr_valid = 1; chr_data = 8'h77;
    rd(0, 32'hC000_01F1, "R8 same cycle");
    rd(0, 32'hE000_01F1, "R8 set wins");
    rd(0, 32'hC000_01F1, "R8 cleared");
    // R6 disable
    wr(0, 32'h0);
    chk("R6 irq_out", {31'b0, irq_out}, 0);
    ack_in = 1; #1;
    chk("R9 ack pass", {31'b0, ack_out}, 1);
    chk("R10 no vec", ack_vec, 32'h0);
    ack_in = 0;
    rd(0, 32'h8000_0000, "R6 ctrl");
    // R10 other vector
    wr(0, 32'h0000_00A5);
    chk("R5 irq re-enabled", {31'b0, irq_out}, 1);
    ack_in = 1; #1;
    chk("R10 vec 0A", ack_vec, 32'h0000_00A0);
    ack_in = 0;
    rd(1, 32'h0000_0010, "R4 data 10");
    chk("R5 irq after read", {31'b0, irq_out}, 0);
    repeat (2) @(posedge clk);
    chk("scoreboard empty", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule